// File: doc/BRIEF.md
# Hardwired Timing and Control Sequencer

This block is the hardwired control unit of a small accumulator machine with a 16-bit instruction word. A sequence counter feeds a one-hot time-slot decoder, and a second decoder turns the three opcode bits into eight one-hot class lines. Gates combine the slots and class lines with the indirect flag, the operation bits of the instruction and the datapath status. The outputs are the strobes that steer a shared bus and the registers around it: a bus source code, load, increment and clear for each register, memory read and write, accumulator operation codes and flag set and clear lines. The datapath, including the instruction register and memory, lies outside the block. Its instruction register drives the `ir` input.

Each instruction is fetched in three slots and may take one more slot to follow an indirect pointer. It then executes as a memory-reference, register-reference or I/O operation. When interrupts are enabled and either device flag is up outside the fetch slots, an internal interrupt bit is raised. The next three slots then run a hardware call instead of a fetch. That call writes the return address to location 0 and continues at location 1. A halt operation stops the counter until the next reset.

Top module: `seq_ctl_unit`

## Requirements
- R1: After reset `slot` equals 1 (T0). While running, `slot` is one-hot and moves up one position per clock. When an instruction's final slot ends, the next cycle is T0.
- R2: When `int_cycle` is 0, fetch runs as follows. At T0, `bus_sel`=2 (PC) and `ar_ld` is high. At T1, `bus_sel`=7 (memory), `mem_rd`, `ir_ld` and `pc_inc` are high. At T2, `bus_sel`=5 (IR) and `ar_ld` is high, and bit 15 of `ir` is captured as the indirect flag.
- R3: At T3 with opcode `ir[14:12]` below 7, an indirect flag of 1 gives `mem_rd`, `bus_sel`=7 and `ar_ld`. A flag of 0 gives no bus source.
- R4: Memory-reference execution depends on the opcode. Opcodes 0, 1, 2 and 6 read memory into DR at T4. Opcodes 0, 1 and 2 end at T5 with `ac_op` 1 (AND), 2 (ADD) and 3 (load) respectively. Opcode 3 drives AC (`bus_sel`=4) and writes memory at T4. Opcode 4 drives AR (`bus_sel`=1) into PC at T4. Opcode 5 drives PC, writes memory and increments AR at T4, then drives AR into PC at T5. Opcode 6 increments DR at T5, then at T6 drives DR (`bus_sel`=3) and writes memory, with `pc_inc` equal to `dr_zero`. The instruction length in slots is 6, 6, 6, 5, 5, 6 and 7 for opcodes 0 through 6.
- R5: Opcode 7 with `ir[15]`=0 is a register operation at T3 that ends the instruction. Bit 11 gives `ac_op`=8 (clear), bit 9 gives 5 (complement), bit 7 gives 6 (rotate right), bit 6 gives 7 (rotate left) and bit 5 gives 9 (increment). Bit 10 raises `e_clr` and bit 8 raises `e_flip`.
- R6: In a register operation, `pc_inc` is raised in four cases: bit 4 with `ac_neg`=0, bit 3 with `ac_neg`=1, bit 2 with `ac_zero`=1, and bit 1 with `e_val`=0.
- R7: Opcode 7 with `ir[15]`=1 is an I/O operation at T3 that ends the instruction. Bit 11 gives `ac_op`=4 and `fgi_clr`. Bit 10 gives `bus_sel`=4 with `outr_ld` and `fgo_clr`. Bit 9 gives `pc_inc` if `in_flag` is set, and bit 8 gives `pc_inc` if `out_flag` is set. Bit 7 sets `int_en` and bit 6 clears it.
- R8: `int_cycle` rises only after a cycle outside T0..T2 in which `int_en` was 1 and `in_flag` or `out_flag` was 1. It never rises while `int_en` is 0.
- R9: With `int_cycle` at 1, the three slots run as follows. T0 gives `bus_sel`=2, `tr_ld` and `ar_clr`. T1 gives `bus_sel`=6, `mem_wr` and `pc_clr`, with no `ir_ld`. T2 gives `pc_inc`. The cycle after that is T0 with `int_cycle` and `int_en` both 0.
- R10: Register bit 0 (halt) drops `running`. From the next cycle, `slot` is 0 and no bus source or memory strobe is active until reset.
- R11: Reset leaves `running`=1, `int_en`=0 and `int_cycle`=0.
- R12: `bus_sel` encodes the single active source as 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR and 7 memory, with 0 for none. At most one source request is active in a cycle. `mem_rd` implies `bus_sel`=7, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 16 | Instruction register contents from the datapath |
| ac_neg | input | 1 | Accumulator sign bit |
| ac_zero | input | 1 | Accumulator equals zero |
| e_val | input | 1 | Carry/extension bit |
| in_flag | input | 1 | Input device has a character |
| out_flag | input | 1 | Output device is ready |
| dr_zero | input | 1 | Data register equals zero |
| bus_sel | output | 3 | Shared bus source code |
| ar_ld | output | 1 | Load address register from bus |
| ar_inc | output | 1 | Increment address register |
| ar_clr | output | 1 | Clear address register |
| pc_ld | output | 1 | Load program counter from bus |
| pc_inc | output | 1 | Increment program counter |
| pc_clr | output | 1 | Clear program counter |
| dr_ld | output | 1 | Load data register from bus |
| dr_inc | output | 1 | Increment data register |
| ir_ld | output | 1 | Load instruction register from bus |
| tr_ld | output | 1 | Load temporary register from bus |
| outr_ld | output | 1 | Load output character register from bus |
| ac_op | output | 4 | Accumulator operation code (0 hold) |
| e_clr | output | 1 | Clear extension bit |
| e_flip | output | 1 | Complement extension bit |
| fgi_clr | output | 1 | Clear input flag |
| fgo_clr | output | 1 | Clear output flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| slot | output | 16 | One-hot time slot |
| int_cycle | output | 1 | Interrupt cycle in progress |
| int_en | output | 1 | Interrupt enable state |
| running | output | 1 | Start/stop state |

## Verification
The bench builds the unit with its default values: a 4-bit counter, a 3-bit opcode and a 16-bit instruction. At that size every opcode can be paired with both values of the indirect bit. Every single operation bit of the register and I/O groups is swept, and each skip test runs under all eight combinations of sign, zero and extension status. The interrupt entry and exit, the disabled-interrupt case, both outcomes of increment-and-skip and the halt stop are driven as directed sequences with cycle-exact expectations.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ACO_HOLD = 4'd0,
    ACO_AND  = 4'd1,
    ACO_ADD  = 4'd2,
    ACO_LOAD = 4'd3,
    ACO_INP  = 4'd4,
    ACO_CMPL = 4'd5,
    ACO_SHR  = 4'd6,
    ACO_SHL  = 4'd7,
    ACO_CLR  = 4'd8,
    ACO_INC  = 4'd9
  } ac_op_e;

  localparam int NSRC = 8;

  // Encoder over the source requests; OR of indices, no priority
  function automatic logic [2:0] bus_encode(input logic [NSRC-1:1] req);
    logic [2:0] s;
    s = '0;
    for (int i = 1; i < NSRC; i++)
      if (req[i]) s = s | 3'(i);
    return s;
  endfunction

  // sel = {neg-clear test, neg-set test, zero test, e-clear test}
  function automatic logic reg_skip(input logic [3:0] sel, input logic neg,
                                    input logic zero, input logic e);
    return (sel[3] & ~neg) | (sel[2] & neg) | (sel[1] & zero) | (sel[0] & ~e);
  endfunction

  function automatic logic io_skip(input logic [1:0] sel, input logic fin,
                                   input logic fout);
    return (sel[1] & fin) | (sel[0] & fout);
  endfunction

  // b = operation bits 11..5 of a register instruction
  function automatic ac_op_e reg_acop(input logic [6:0] b);
    if (b[6])      return ACO_CLR;
    else if (b[4]) return ACO_CMPL;
    else if (b[2]) return ACO_SHR;
    else if (b[1]) return ACO_SHL;
    else if (b[0]) return ACO_INC;
    return ACO_HOLD;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int SC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   clr,
  output logic [(1<<SC_W)-1:0]   slot
);
  localparam int NSLOT = 1 << SC_W;

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sc_q <= '0;
    else if (run) sc_q <= clr ? '0 : sc_q + SC_W'(1);
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      assign slot[g] = run & (sc_q == SC_W'(g));
    end
  endgenerate
endmodule

// File: rtl/seq_opdec.sv
module seq_opdec #(
  parameter int OP_W = 3
) (
  input  logic [OP_W-1:0]       opc,
  output logic [(1<<OP_W)-1:0]  cls
);
  localparam int NOPC = 1 << OP_W;

  generate
    for (genvar g = 0; g < NOPC; g++) begin : g_cls
      assign cls[g] = (opc == OP_W'(g));
    end
  endgenerate
endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
  import seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NOPC  = 8
) (
  input  logic [NSLOT-1:0] slot,
  input  logic [NOPC-1:0]  cls,
  input  logic             iflag,
  input  logic             irq,
  input  logic [11:0]      opb,
  input  logic             ac_neg,
  input  logic             ac_zero,
  input  logic             e_val,
  input  logic             in_flag,
  input  logic             out_flag,
  input  logic             dr_zero,
  output logic [NSRC-1:1]  src_req,
  output logic             ar_ld, ar_inc, ar_clr,
  output logic             pc_ld, pc_inc, pc_clr,
  output logic             dr_ld, dr_inc,
  output logic             ir_ld, tr_ld, outr_ld,
  output ac_op_e           ac_op,
  output logic             e_clr, e_flip,
  output logic             fgi_clr, fgo_clr,
  output logic             mem_wr,
  output logic             sc_clr,
  output logic             halt_req,
  output logic             ien_set, ien_clr,
  output logic             irq_clr,
  output logic             iflag_ld
);
  localparam int XC = NOPC - 1;   // class of register and I/O operations

  logic ft0, ft1, ft2, it0, it1, it2;
  logic ind, rop, iop, rd_t4;

  always_comb begin
    ft0 = ~irq & slot[0];
    ft1 = ~irq & slot[1];
    ft2 = ~irq & slot[2];
    it0 =  irq & slot[0];
    it1 =  irq & slot[1];
    it2 =  irq & slot[2];
    ind = ~cls[XC] &  iflag & slot[3];
    rop =  cls[XC] & ~iflag & slot[3];
    iop =  cls[XC] &  iflag & slot[3];
    rd_t4 = (cls[0] | cls[1] | cls[2] | cls[6]) & slot[4];

    src_req    = '0;
    src_req[1] = (cls[4] & slot[4]) | (cls[5] & slot[5]);
    src_req[2] = ft0 | it0 | (cls[5] & slot[4]);
    src_req[3] = cls[6] & slot[6];
    src_req[4] = (cls[3] & slot[4]) | (iop & opb[10]);
    src_req[5] = ft2;
    src_req[6] = it1;
    src_req[7] = ft1 | ind | rd_t4;

    mem_wr  = it1 | (cls[3] & slot[4]) | (cls[5] & slot[4]) | (cls[6] & slot[6]);
    ar_ld   = ft0 | ft2 | ind;
    ar_clr  = it0;
    ar_inc  = cls[5] & slot[4];
    pc_ld   = (cls[4] & slot[4]) | (cls[5] & slot[5]);
    pc_clr  = it1;
    pc_inc  = ft1 | it2 | (cls[6] & slot[6] & dr_zero)
            | (rop & reg_skip(opb[4:1], ac_neg, ac_zero, e_val))
            | (iop & io_skip(opb[9:8], in_flag, out_flag));
    dr_ld   = rd_t4;
    dr_inc  = cls[6] & slot[5];
    ir_ld   = ft1;
    tr_ld   = it0;
    outr_ld = iop & opb[10];
    e_clr   = rop & opb[10];
    e_flip  = rop & opb[8];
    fgi_clr = iop & opb[11];
    fgo_clr = iop & opb[10];

    ac_op = ACO_HOLD;
    if (slot[5] & cls[0])      ac_op = ACO_AND;
    else if (slot[5] & cls[1]) ac_op = ACO_ADD;
    else if (slot[5] & cls[2]) ac_op = ACO_LOAD;
    else if (iop & opb[11])    ac_op = ACO_INP;
    else if (rop)              ac_op = reg_acop(opb[11:5]);

    sc_clr   = it2 | rop | iop
             | ((cls[0] | cls[1] | cls[2]) & slot[5])
             | ((cls[3] | cls[4]) & slot[4])
             | (cls[5] & slot[5]) | (cls[6] & slot[6]);
    halt_req = rop & opb[0];
    ien_set  = iop & opb[7];
    ien_clr  = (iop & opb[6]) | it2;
    irq_clr  = it2;
    iflag_ld = ft2;
  end
endmodule

// File: rtl/seq_ctl_unit.sv
module seq_ctl_unit
  import seq_pkg::*;
#(
  parameter int SC_W = 4,
  parameter int OP_W = 3,
  parameter int IR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IR_W-1:0]       ir,
  input  logic                  ac_neg,
  input  logic                  ac_zero,
  input  logic                  e_val,
  input  logic                  in_flag,
  input  logic                  out_flag,
  input  logic                  dr_zero,
  output logic [2:0]            bus_sel,
  output logic                  ar_ld,
  output logic                  ar_inc,
  output logic                  ar_clr,
  output logic                  pc_ld,
  output logic                  pc_inc,
  output logic                  pc_clr,
  output logic                  dr_ld,
  output logic                  dr_inc,
  output logic                  ir_ld,
  output logic                  tr_ld,
  output logic                  outr_ld,
  output logic [3:0]            ac_op,
  output logic                  e_clr,
  output logic                  e_flip,
  output logic                  fgi_clr,
  output logic                  fgo_clr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [(1<<SC_W)-1:0]  slot,
  output logic                  int_cycle,
  output logic                  int_en,
  output logic                  running
);
  localparam int NSLOT = 1 << SC_W;
  localparam int NOPC  = 1 << OP_W;
  localparam int ADR_W = IR_W - 1 - OP_W;

  logic [NOPC-1:0]  cls;
  logic [NSRC-1:1]  src_req;
  logic             sc_clr, halt_req, ien_set, ien_clr, irq_clr, iflag_ld;
  logic             irq_set;
  logic             iflag_q, ien_q, irq_q, run_q;
  ac_op_e           ac_op_w;

  seq_timer #(.SC_W(SC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clr(sc_clr), .slot(slot)
  );

  seq_opdec #(.OP_W(OP_W)) u_opdec (
    .opc(ir[IR_W-2 -: OP_W]), .cls(cls)
  );

  seq_strobes #(.NSLOT(NSLOT), .NOPC(NOPC)) u_strobes (
    .slot(slot), .cls(cls), .iflag(iflag_q), .irq(irq_q), .opb(ir[11:0]),
    .ac_neg(ac_neg), .ac_zero(ac_zero), .e_val(e_val),
    .in_flag(in_flag), .out_flag(out_flag), .dr_zero(dr_zero),
    .src_req(src_req),
    .ar_ld(ar_ld), .ar_inc(ar_inc), .ar_clr(ar_clr),
    .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr),
    .dr_ld(dr_ld), .dr_inc(dr_inc),
    .ir_ld(ir_ld), .tr_ld(tr_ld), .outr_ld(outr_ld),
    .ac_op(ac_op_w), .e_clr(e_clr), .e_flip(e_flip),
    .fgi_clr(fgi_clr), .fgo_clr(fgo_clr), .mem_wr(mem_wr),
    .sc_clr(sc_clr), .halt_req(halt_req),
    .ien_set(ien_set), .ien_clr(ien_clr), .irq_clr(irq_clr),
    .iflag_ld(iflag_ld)
  );

  // Interrupt request: outside the first three slots only
  assign irq_set = run_q & ~(slot[0] | slot[1] | slot[2]) & ien_q & (in_flag | out_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iflag_q <= 1'b0;
      ien_q   <= 1'b0;
      irq_q   <= 1'b0;
      run_q   <= 1'b1;
    end else begin
      if (iflag_ld) iflag_q <= ir[IR_W-1];
      if (ien_clr)      ien_q <= 1'b0;
      else if (ien_set) ien_q <= 1'b1;
      if (irq_clr)      irq_q <= 1'b0;
      else if (irq_set) irq_q <= 1'b1;
      if (halt_req)     run_q <= 1'b0;
    end
  end

  assign bus_sel   = bus_encode(src_req);
  assign mem_rd    = src_req[7];
  assign ac_op     = ac_op_w;
  assign int_cycle = irq_q;
  assign int_en    = ien_q;
  assign running   = run_q;

  logic unused_ok;
  assign unused_ok = ^{cls[NOPC-1], ir[ADR_W-1:0]};
endmodule

// File: rtl/seq_ctl_chk.sv
module seq_ctl_chk #(
  parameter int SC_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [(1<<SC_W)-1:0]  slot,
  input logic [7:1]            src_req,
  input logic [2:0]            bus_sel,
  input logic                  mem_rd,
  input logic                  mem_wr,
  input logic                  int_cycle,
  input logic                  int_en,
  input logic                  running,
  input logic                  sc_clr,
  input logic                  halt_req
);
  localparam int NSLOT = 1 << SC_W;

  // R1
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sc_clr && !slot[NSLOT-1]) |=> (slot == ($past(slot) << 1)));

  // R1
  slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sc_clr && !halt_req) |=> slot[0]);

  // R12
  bus_req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_req));

  // R12
  mem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_sel == 3'd7));

  // R12
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_cycle) |-> ($past(int_en) && !$past(slot[0]) && !$past(slot[1]) && !$past(slot[2])));

  // R9
  irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_cycle && slot[2]) |=> (!int_cycle && !int_en && slot[0]));

  // R10
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (!running && slot == '0 && !mem_rd && !mem_wr));
endmodule

bind seq_ctl_unit seq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .src_req(src_req), .bus_sel(bus_sel),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .int_cycle(int_cycle), .int_en(int_en),
  .running(running), .sc_clr(sc_clr), .halt_req(halt_req)
);

// File: tb/sim_seq_ctl_unit.sv
module sim_seq_ctl_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ir = '0;
  logic ac_neg = 0, ac_zero = 0, e_val = 0, in_flag = 0, out_flag = 0, dr_zero = 0;
  logic [2:0] bus_sel;
  logic ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr, dr_ld, dr_inc;
  logic ir_ld, tr_ld, outr_ld, e_clr, e_flip, fgi_clr, fgo_clr, mem_rd, mem_wr;
  logic [3:0] ac_op;
  logic [15:0] slot;
  logic int_cycle, int_en, running;

  int n_chk = 0;
  int n_fail = 0;

  seq_ctl_unit u0 (
    .clk(clk), .rst_n(rst_n), .ir(ir), .ac_neg(ac_neg), .ac_zero(ac_zero),
    .e_val(e_val), .in_flag(in_flag), .out_flag(out_flag), .dr_zero(dr_zero),
    .bus_sel(bus_sel), .ar_ld(ar_ld), .ar_inc(ar_inc), .ar_clr(ar_clr),
    .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr), .dr_ld(dr_ld), .dr_inc(dr_inc),
    .ir_ld(ir_ld), .tr_ld(tr_ld), .outr_ld(outr_ld), .ac_op(ac_op),
    .e_clr(e_clr), .e_flip(e_flip), .fgi_clr(fgi_clr), .fgo_clr(fgo_clr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .slot(slot), .int_cycle(int_cycle),
    .int_en(int_en), .running(running)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_len(input logic [15:0] w);
    case (w[14:12])
      3'd7:       return 4;
      3'd3, 3'd4: return 5;
      3'd6:       return 7;
      default:    return 6;
    endcase
  endfunction

  function automatic logic [2:0] exp_bus(input logic [15:0] w, input int k);
    int op = int'(w[14:12]);
    if (k == 0) return 3'd2;
    if (k == 1) return 3'd7;
    if (k == 2) return 3'd5;
    if (k == 3) begin
      if (op != 7) return w[15] ? 3'd7 : 3'd0;
      return (w[15] && w[10]) ? 3'd4 : 3'd0;
    end
    if (k == 4) begin
      if (op == 3) return 3'd4;
      if (op == 4) return 3'd1;
      if (op == 5) return 3'd2;
      return 3'd7;
    end
    if (k == 5) return (op == 5) ? 3'd1 : 3'd0;
    return (op == 6) ? 3'd3 : 3'd0;
  endfunction

  function automatic logic exp_wr(input logic [15:0] w, input int k);
    int op = int'(w[14:12]);
    return (k == 4 && (op == 3 || op == 5)) || (k == 6 && op == 6);
  endfunction

  function automatic logic [3:0] exp_reg_op(input logic [15:0] w);
    if (w[11]) return 4'd8;
    if (w[9])  return 4'd5;
    if (w[7])  return 4'd6;
    if (w[6])  return 4'd7;
    if (w[5])  return 4'd9;
    return 4'd0;
  endfunction

  task automatic cyc_checks(input logic [15:0] w, input int k);
    int op = int'(w[14:12]);
    if (k == 0) chk("R2", "ar_ld@T0", ar_ld, 1);
    if (k == 1) begin
      chk("R2", "ir_ld@T1", ir_ld, 1);
      chk("R2", "pc_inc@T1", pc_inc, 1);
    end
    if (k == 2) chk("R2", "ar_ld@T2", ar_ld, 1);
    if (k == 3 && op != 7) chk("R3", "ar_ld@T3", ar_ld, w[15]);
    if (k == 3 && op == 7 && !w[15]) begin
      logic sk;
      sk = (w[4] && !ac_neg) || (w[3] && ac_neg) || (w[2] && ac_zero) || (w[1] && !e_val);
      chk("R5", "ac_op reg", ac_op, exp_reg_op(w));
      chk("R5", "e_clr", e_clr, w[10]);
      chk("R5", "e_flip", e_flip, w[8]);
      chk("R6", "pc_inc skip", pc_inc, sk);
    end
    if (k == 3 && op == 7 && w[15]) begin
      chk("R7", "ac_op io", ac_op, w[11] ? 4'd4 : 4'd0);
      chk("R7", "fgi_clr", fgi_clr, w[11]);
      chk("R7", "outr_ld", outr_ld, w[10]);
      chk("R7", "fgo_clr", fgo_clr, w[10]);
      chk("R7", "pc_inc io skip", pc_inc, (w[9] && in_flag) || (w[8] && out_flag));
    end
    if (k == 4 && op == 5) chk("R4", "ar_inc bsa", ar_inc, 1);
    if (k == 4 && op == 4) chk("R4", "pc_ld bun", pc_ld, 1);
    if (k == 4 && (op <= 2 || op == 6)) chk("R4", "dr_ld", dr_ld, 1);
    if (k == 5 && op <= 2) chk("R4", "ac_op mem", ac_op, 4'(op + 1));
    if (k == 5 && op == 5) chk("R4", "pc_ld bsa", pc_ld, 1);
    if (k == 5 && op == 6) chk("R4", "dr_inc isz", dr_inc, 1);
    if (k == 6 && op == 6) chk("R4", "pc_inc isz", pc_inc, dr_zero);
  endtask

  task automatic run_instr(input logic [15:0] w);
    int len = exp_len(w);
    ir = w;
    for (int k = 0; k < len; k++) begin
      #1;
      chk("R1", $sformatf("slot k=%0d ir=%h", k, w), slot, 32'(1) << k);
      chk("R12", $sformatf("bus_sel k=%0d ir=%h", k, w), bus_sel, exp_bus(w, k));
      chk("R12", $sformatf("mem_rd k=%0d ir=%h", k, w), mem_rd, exp_bus(w, k) == 3'd7);
      chk("R4", $sformatf("mem_wr k=%0d ir=%h", k, w), mem_wr, exp_wr(w, k));
      cyc_checks(w, k);
      tick();
    end
    #1;
    chk("R1", $sformatf("back to T0 ir=%h", w), slot, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    // R11 / R1 reset state
    chk("R11", "running", running, 1);
    chk("R11", "int_en", int_en, 0);
    chk("R11", "int_cycle", int_cycle, 0);
    chk("R1", "slot after reset", slot, 1);

    // R8: flag up while interrupts disabled
    in_flag = 1'b1;
    run_instr(16'h2000);
    chk("R8", "no irq when disabled", int_cycle, 0);
    in_flag = 1'b0;

    // R2 R3 R4: every memory-reference opcode, both addressing modes
    for (int op = 0; op < 7; op++) begin
      for (int ib = 0; ib < 2; ib++) begin
        dr_zero = 1'b0;
        run_instr({ib[0], op[2:0], 12'h123});
        if (op == 6) begin
          dr_zero = 1'b1;
          run_instr({ib[0], op[2:0], 12'h456});
        end
      end
    end
    dr_zero = 1'b0;

    // R5 R6: each register bit except halt, all status combinations
    for (int b = 1; b < 12; b++) begin
      for (int s = 0; s < 8; s++) begin
        ac_neg = s[0]; ac_zero = s[1]; e_val = s[2];
        run_instr(16'h7000 | (16'h1 << b));
      end
    end
    ac_neg = 0; ac_zero = 0; e_val = 0;

    // R7: each I/O bit, flags both ways for the skip tests
    for (int b = 11; b >= 6; b--) begin
      for (int f = 0; f < 2; f++) begin
        if (f == 1 && !(b == 9 || b == 8)) continue;
        in_flag = f[0]; out_flag = f[0];
        run_instr(16'hF000 | (16'h1 << b));
        in_flag = 0; out_flag = 0;
        if (b == 7) chk("R7", "int_en after enable", int_en, 1);
        if (b == 6) chk("R7", "int_en after disable", int_en, 0);
      end
    end

    // R8 R9: enable, raise input flag during a store, take interrupt
    run_instr(16'hF080);
    chk("R7", "int_en set", int_en, 1);
    in_flag = 1'b1;
    run_instr(16'h3000);
    chk("R8", "irq raised", int_cycle, 1);
    chk("R9", "T0 bus PC", bus_sel, 3'd2);
    chk("R9", "T0 tr_ld", tr_ld, 1);
    chk("R9", "T0 ar_clr", ar_clr, 1);
    chk("R2", "no ar_ld in irq T0", ar_ld, 0);
    tick(); #1;
    chk("R9", "T1 bus TR", bus_sel, 3'd6);
    chk("R9", "T1 mem_wr", mem_wr, 1);
    chk("R9", "T1 pc_clr", pc_clr, 1);
    chk("R9", "T1 no ir_ld", ir_ld, 0);
    tick(); #1;
    chk("R9", "T2 pc_inc", pc_inc, 1);
    chk("R9", "T2 slot", slot, 16'h0004);
    tick(); #1;
    chk("R9", "exit slot T0", slot, 1);
    chk("R9", "exit int_cycle", int_cycle, 0);
    chk("R9", "exit int_en", int_en, 0);
    in_flag = 1'b0;

    // R10: halt
    ir = 16'h7001;
    tick(); tick(); tick();
    #1;
    chk("R10", "halt at T3 slot", slot, 16'h0008);
    tick(); #1;
    chk("R10", "running low", running, 0);
    chk("R10", "slot idle", slot, 0);
    chk("R10", "no bus source", bus_sel, 0);
    chk("R10", "no mem_rd", mem_rd, 0);
    tick(); tick(); tick(); #1;
    chk("R10", "still idle", slot, 0);
    chk("R10", "still no write", mem_wr, 0);

    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    #1;
    chk("R11", "running after reset", running, 1);
    chk("R1", "slot after second reset", slot, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule